// File: doc/BRIEF.md
# Dual-Size Segment Lookaside Buffer

A small, fully associative table that turns the segment part of a 64-bit effective address into a stored virtual segment word. Each slot holds three things: a segment number, a valid bit and a 64-bit VSID word. The VSID word carries the segment-size code in bits 63:62. Two segment sizes are supported, 256 MB and 1 TB. Each slot masks the incoming address at the boundary set by its own size code. Lookup is combinational, and the lowest-numbered matching slot wins.

Entries are loaded through a write port that takes a slot/ESID word and a VSID word. The pair is checked for illegal encodings first. A rejected write leaves the table unchanged and raises a one-cycle error pulse. Software-visible state can be read back through a slot read port, which returns the stored ESID word. Single slots can be invalidated, and reset clears every valid bit. Page table walking and hashing are handled elsewhere.

Top module: `seg_lookaside`

## Requirements
- R1: After reset every slot is invalid: any lookup misses, and read-back of any slot returns bit 27 (valid) as 0.
- R2: An accepted write targets the slot given by slot/ESID word bits 11:0. From the next clock edge, read-back of that slot returns bits 63:27 of the written word with bits 26:0 zero. No size bits appear in the returned word.
- R3: A write whose slot field (bits 11:0) is at or above the entry count is rejected. The table is left unchanged and `wr_err_o` is high for exactly the cycle after the write.
- R4: A write whose VSID size code (bits 63:62) is 10 or 11 is rejected with the same error pulse, and the table is unchanged.
- R5: A write with size code 01 (1 TB) is rejected when `big_seg_en_i` is low and accepted when it is high. Code 00 (256 MB) is always legal.
- R6: A valid slot with size code 00 matches when its stored segment number equals address bits 63:28. On a hit, `lk_vsid_o` returns the stored VSID word and `lk_slot_o` the slot index.
- R7: A valid slot with size code 01 matches when its stored bits 63:40 equal address bits 63:40 and its stored bits 39:28 are zero. Address bits 39:0 do not affect the match.
- R8: When several slots match, the lowest slot index is returned.
- R9: Asserting `inv_en_i` clears the valid bit of slot `inv_slot_i` at the next edge and leaves the other slots untouched.
- R10: A read-back index at or above the entry count sets `rd_err_o` and returns zero data.
- R11: On a miss, `lk_hit_o` is 0 and both `lk_slot_o` and `lk_vsid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| big_seg_en_i | input | 1 | 1 TB segments permitted |
| wr_en_i | input | 1 | Write request |
| wr_esid_i | input | 64 | Segment number 63:28, valid 27, slot 11:0 |
| wr_vsid_i | input | 64 | VSID word, size code 63:62 |
| wr_err_o | output | 1 | Rejected-write pulse, one cycle after the write |
| inv_en_i | input | 1 | Invalidate request |
| inv_slot_i | input | IDX_W | Slot to invalidate |
| lk_addr_i | input | 64 | Effective address to look up |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | IDX_W | Matching slot |
| lk_vsid_o | output | 64 | VSID word of the matching slot |
| rd_slot_i | input | 12 | Read-back slot index |
| rd_esid_o | output | 64 | Stored ESID word |
| rd_err_o | output | 1 | Read-back index out of range |

## Verification
The assertions assume that a write and an invalidate do not target the same slot in the same cycle, although the RTL gives the write priority if they do. They also assume that the size input is held stable around each write. The stimulus drives every input half a cycle away from the sampling edge. Random writes pick slots and size codes, including out-of-range slots and reserved codes, and never pair a write with an invalidate. Directed cases deliberately place overlapping 256 MB and 1 TB entries to exercise first-match ordering. In the random phase, lookups are aimed at addresses derived from stored entries.

// File: rtl/seg_lab_pkg.sv
package seg_lab_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned SLOT_FW  = 12;
  localparam int unsigned VLD_BIT  = 27;
  localparam int unsigned LO_SMALL = 28;
  localparam int unsigned LO_BIG   = 40;
  localparam int unsigned SEG_W    = WORD_W - LO_SMALL;
  localparam int unsigned ZPAD_W   = LO_BIG - LO_SMALL;
  localparam logic [1:0]  SZ_SMALL = 2'b00;
  localparam logic [1:0]  SZ_BIG   = 2'b01;
endpackage

// File: rtl/seg_wr_check.sv
module seg_wr_check #(
  parameter int unsigned ENTRIES = 64
) (
  input  logic        wr_en_i,
  input  logic [11:0] slot_i,
  input  logic [1:0]  size_i,
  input  logic        big_en_i,
  output logic        ok_o,
  output logic        bad_o
);
  localparam logic [11:0] SLOT_MASK = 12'(ENTRIES - 1);

  logic slot_bad, size_bad;
  assign slot_bad = |(slot_i & ~SLOT_MASK);
  assign size_bad = size_i[1] | (size_i[0] & ~big_en_i);
  assign bad_o    = wr_en_i & (slot_bad | size_bad);
  assign ok_o     = wr_en_i & ~(slot_bad | size_bad);
endmodule

// File: rtl/seg_entry.sv
module seg_entry
  import seg_lab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              inv_i,
  input  logic [WORD_W-1:0] esid_i,
  input  logic [WORD_W-1:0] vsid_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              match_o,
  output logic [WORD_W-1:0] esid_o,
  output logic [WORD_W-1:0] vsid_o
);
  logic [SEG_W-1:0]  seg_q;
  logic              vld_q;
  logic [WORD_W-1:0] vsid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= '0;
      vld_q  <= 1'b0;
      vsid_q <= '0;
    end else if (ld_i) begin
      seg_q  <= esid_i[WORD_W-1:LO_SMALL];
      vld_q  <= esid_i[VLD_BIT];
      vsid_q <= vsid_i;
    end else if (inv_i) begin
      vld_q  <= 1'b0;
    end
  end

  logic [1:0] sz;
  logic       hit_small, hit_big;
  assign sz        = vsid_q[WORD_W-1 -: 2];
  assign hit_small = (sz == SZ_SMALL) && (seg_q == addr_i[WORD_W-1:LO_SMALL]);
  assign hit_big   = (sz == SZ_BIG) &&
                     (seg_q == {addr_i[WORD_W-1:LO_BIG], {ZPAD_W{1'b0}}});
  assign match_o   = vld_q & (hit_small | hit_big);
  assign esid_o    = {seg_q, vld_q, {VLD_BIT{1'b0}}};
  assign vsid_o    = vsid_q;

  // R4
  size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> !vsid_q[WORD_W-1]);
  // R2
  load_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> vld_q == $past(esid_i[VLD_BIT]));
  // R9
  inv_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !ld_i) |=> !vld_q);
endmodule

// File: rtl/seg_first_pick.sv
module seg_first_pick #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
  import seg_lab_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_seg_en_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_esid_i,
  input  logic [WORD_W-1:0] wr_vsid_i,
  output logic              wr_err_o,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_slot_i,
  input  logic [WORD_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_slot_o,
  output logic [WORD_W-1:0] lk_vsid_o,
  input  logic [11:0]       rd_slot_i,
  output logic [WORD_W-1:0] rd_esid_o,
  output logic              rd_err_o
);
  localparam logic [11:0] SLOT_MASK = 12'(ENTRIES - 1);

  logic wr_ok, wr_bad;
  seg_wr_check #(.ENTRIES(ENTRIES)) u_chk (
    .wr_en_i (wr_en_i),
    .slot_i  (wr_esid_i[SLOT_FW-1:0]),
    .size_i  (wr_vsid_i[WORD_W-1 -: 2]),
    .big_en_i(big_seg_en_i),
    .ok_o    (wr_ok),
    .bad_o   (wr_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= wr_bad;
  end

  logic [IDX_W-1:0]  wr_idx;
  logic [ENTRIES-1:0] match;
  logic [WORD_W-1:0] esid_arr [ENTRIES];
  logic [WORD_W-1:0] vsid_arr [ENTRIES];
  assign wr_idx = wr_esid_i[IDX_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    seg_entry u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (wr_ok && (wr_idx == IDX_W'(g))),
      .inv_i  (inv_en_i && (inv_slot_i == IDX_W'(g))),
      .esid_i (wr_esid_i),
      .vsid_i (wr_vsid_i),
      .addr_i (lk_addr_i),
      .match_o(match[g]),
      .esid_o (esid_arr[g]),
      .vsid_o (vsid_arr[g])
    );
  end

  logic [ENTRIES-1:0] gnt;
  logic [IDX_W-1:0]   pick_idx;
  logic               any_hit;
  seg_first_pick #(.N(ENTRIES)) u_pick (
    .req_i(match),
    .gnt_o(gnt),
    .idx_o(pick_idx),
    .any_o(any_hit)
  );

  assign lk_hit_o  = any_hit;
  assign lk_slot_o = any_hit ? pick_idx : '0;
  assign lk_vsid_o = any_hit ? vsid_arr[pick_idx] : '0;

  assign rd_err_o  = |(rd_slot_i & ~SLOT_MASK);
  assign rd_esid_o = rd_err_o ? '0 : esid_arr[rd_slot_i[IDX_W-1:0]];

  // R3
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i));
  // R8
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && (any_hit == (gnt != '0)));
  // R6
  hit_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> !lk_vsid_o[WORD_W-1]);
  // R10
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_esid_o == '0);
endmodule

// File: tb/seg_lookaside_bench.sv
`timescale 1ns/1ps
module seg_lookaside_bench;
  localparam int ENTRIES = 64;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              big_en = 1'b1, wr_en = 1'b0, inv_en = 1'b0;
  logic [63:0]       wr_esid = '0, wr_vsid = '0, lk_addr = '0;
  logic [IDX_W-1:0]  inv_slot = '0;
  logic [11:0]       rd_slot = '0;
  logic              wr_err, lk_hit, rd_err;
  logic [IDX_W-1:0]  lk_slot;
  logic [63:0]       lk_vsid, rd_esid;

  seg_lookaside #(.ENTRIES(ENTRIES)) u_seg_lookaside (
    .clk_i(clk), .rst_ni(rst_n), .big_seg_en_i(big_en),
    .wr_en_i(wr_en), .wr_esid_i(wr_esid), .wr_vsid_i(wr_vsid), .wr_err_o(wr_err),
    .inv_en_i(inv_en), .inv_slot_i(inv_slot),
    .lk_addr_i(lk_addr), .lk_hit_o(lk_hit), .lk_slot_o(lk_slot), .lk_vsid_o(lk_vsid),
    .rd_slot_i(rd_slot), .rd_esid_o(rd_esid), .rd_err_o(rd_err)
  );

  int errors = 0, checks = 0, multi = 0;
  bit done = 0;
  logic [35:0] m_seg [ENTRIES];
  logic        m_vld [ENTRIES];
  logic [63:0] m_vsid [ENTRIES];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit m_match(int i, logic [63:0] a);
    if (!m_vld[i]) return 0;
    if (m_vsid[i][63:62] == 2'b00) return m_seg[i] == a[63:28];
    if (m_vsid[i][63:62] == 2'b01) return m_seg[i] == {a[63:40], 12'h000};
    return 0;
  endfunction

  function automatic int m_first(logic [63:0] a);
    for (int i = 0; i < ENTRIES; i++) if (m_match(i, a)) return i;
    return -1;
  endfunction

  function automatic int m_count(logic [63:0] a);
    int c = 0;
    for (int i = 0; i < ENTRIES; i++) if (m_match(i, a)) c++;
    return c;
  endfunction

  function automatic logic [63:0] mk_esid(logic [35:0] seg, bit v, int slot);
    return {seg, v, 15'h0, 12'(slot)};
  endfunction

  task automatic do_write(input logic [63:0] e, input logic [63:0] v, input string req);
    bit exp_bad;
    exp_bad = (e[11:0] >= 12'(ENTRIES)) || v[63] || (v[62] && !big_en);
    @(negedge clk);
    wr_esid = e; wr_vsid = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_err == exp_bad, req, {63'h0, wr_err}, {63'h0, exp_bad});
    if (!exp_bad) begin
      m_seg[e[IDX_W-1:0]]  = e[63:28];
      m_vld[e[IDX_W-1:0]]  = e[27];
      m_vsid[e[IDX_W-1:0]] = v;
    end
    @(negedge clk);
    chk(wr_err == 1'b0, {req, " pulse end"}, {63'h0, wr_err}, 64'h0);
  endtask

  task automatic do_look(input logic [63:0] a, input string req);
    int f;
    @(negedge clk);
    lk_addr = a;
    #1;
    f = m_first(a);
    if (m_count(a) > 1) multi++;
    if (f < 0) begin
      chk(!lk_hit && lk_slot == 0 && lk_vsid == 0, req, lk_vsid, 64'h0);
    end else begin
      chk(lk_hit && lk_slot == IDX_W'(f), req, {58'h0, lk_slot}, 64'(f));
      chk(lk_vsid == m_vsid[f], req, lk_vsid, m_vsid[f]);
    end
  endtask

  task automatic do_read(input int s, input string req);
    logic [63:0] exp;
    @(negedge clk);
    rd_slot = 12'(s);
    #1;
    if (s >= ENTRIES) begin
      chk(rd_err && rd_esid == 0, req, rd_esid, 64'h0);
    end else begin
      exp = {m_seg[s], m_vld[s], 27'h0};
      chk(!rd_err && rd_esid == exp, req, rd_esid, exp);
    end
  endtask

  task automatic do_inv(input int s);
    @(negedge clk);
    inv_slot = IDX_W'(s); inv_en = 1'b1;
    @(negedge clk);
    inv_en = 1'b0;
    m_vld[s] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5e61));
    for (int i = 0; i < ENTRIES; i++) begin
      m_seg[i] = '0; m_vld[i] = 1'b0; m_vsid[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    do_read(0, "R1 reset readback");
    do_read(ENTRIES - 1, "R1 reset readback");
    do_look(64'h0, "R1 reset miss");
    do_look(64'hFFFF_FFFF_FFFF_FFFF, "R1 reset miss");

    // R2: store and readback, extra bits dropped
    do_write(mk_esid(36'h1_2345_6789, 1, 5) | 64'h0000_0000_0123_4000, {2'b00, 62'h0ABC_DEF0_1234_5000}, "R2 write");
    do_read(5, "R2 readback");
    // R6: small segment hit and neighbor miss
    do_look({36'h1_2345_6789, 28'hFFF_FFFF}, "R6 small hit");
    do_look({36'h1_2345_678A, 28'h0}, "R11 neighbor miss");

    // R3: slot out of range, table unchanged
    do_write(mk_esid(36'h9_9999_9999, 1, ENTRIES), 64'h0, "R3 high slot");
    do_write(mk_esid(36'h9_9999_9999, 1, 12'hFC5), 64'h0, "R3 reserved bits");
    do_read(5, "R3 unchanged");
    do_look({36'h9_9999_9999, 28'h0}, "R3 no entry");

    // R4: reserved size codes
    do_write(mk_esid(36'h7_7777_7777, 1, 6), {2'b10, 62'h1}, "R4 code 10");
    do_write(mk_esid(36'h7_7777_7777, 1, 6), {2'b11, 62'h1}, "R4 code 11");
    do_read(6, "R4 unchanged");

    // R5: 1 TB gated by config
    big_en = 1'b0;
    do_write(mk_esid({24'hABCDEF, 12'h0}, 1, 7), {2'b01, 62'h77}, "R5 big disabled");
    do_read(7, "R5 unchanged");
    big_en = 1'b1;
    do_write(mk_esid({24'hABCDEF, 12'h0}, 1, 7), {2'b01, 62'h77}, "R5 big enabled");
    // R7: 1 TB match ignores bits 39:0
    do_look({24'hABCDEF, 40'hFF_FFFF_FFFF}, "R7 big hit");
    do_look({24'hABCDEF, 40'h12_3456_789A}, "R7 big hit");
    do_look({24'hABCDF0, 40'h0}, "R7 big miss");
    // R7: stored nonzero 39:28 never matches
    do_write(mk_esid({24'h111111, 12'h001}, 1, 8), {2'b01, 62'h88}, "R7 write");
    do_look({24'h111111, 12'h001, 28'h0}, "R7 nonzero low bits miss");

    // R8: overlapping entries, lowest slot wins
    do_write(mk_esid({24'h222222, 12'h000}, 1, 20), {2'b01, 62'h20}, "R8 write");
    do_write(mk_esid({24'h222222, 12'h000}, 1, 10), {2'b00, 62'h10}, "R8 write");
    do_look({24'h222222, 12'h000, 28'h5}, "R8 first match slot 10");
    do_look({24'h222222, 12'h001, 28'h5}, "R8 only big slot 20");
    // R9: invalidate slot 10, slot 20 then wins
    do_inv(10);
    do_look({24'h222222, 12'h000, 28'h5}, "R9 after invalidate");
    do_read(10, "R9 readback");
    do_read(20, "R9 other slot intact");
    // R2: write with valid bit clear
    do_write(mk_esid(36'h3_3333_3333, 0, 30), 64'h0, "R2 write invalid");
    do_look({36'h3_3333_3333, 28'h0}, "R2 invalid entry miss");

    // R10: readback out of range
    do_read(ENTRIES, "R10 high read");
    do_read(12'hFFF, "R10 high read");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op, s;
      logic [35:0] seg;
      logic [1:0] sz;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        s = ($urandom_range(0, 9) == 0) ? $urandom_range(ENTRIES, 4095) : $urandom_range(0, ENTRIES - 1);
        sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
        seg = {$urandom(), 4'($urandom())};
        if (sz == 2'b01 && $urandom_range(0, 3) != 0) seg[11:0] = '0;
        big_en = ($urandom_range(0, 4) != 0);
        do_write(mk_esid(seg, $urandom_range(0, 5) != 0, s), {sz, 30'($urandom()), 32'($urandom())}, "R2/R3/R4/R5 random write");
      end else if (op < 8) begin
        logic [63:0] a;
        s = $urandom_range(0, ENTRIES - 1);
        a = {$urandom(), $urandom()};
        if ($urandom_range(0, 3) != 0) begin
          if (m_vsid[s][62]) a[63:40] = m_seg[s][35:12];
          else a[63:28] = m_seg[s];
        end
        do_look(a, "R6/R7/R8/R11 random lookup");
      end else if (op == 8) begin
        do_read($urandom_range(0, 95), "R2/R10 random readback");
      end else begin
        do_inv($urandom_range(0, ENTRIES - 1));
      end
    end
    big_en = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule